// File: doc/BRIEF.md
# Debug Breakpoint Comparator

This unit sits beside a processor core and watches each retiring instruction. It holds a small table of watch entries. Each entry can compare the retired program counter, one general-purpose register, or one data-memory word against a 32-bit constant, using one of six unsigned relational operators. A separate entry kind requests a break after every instruction, which gives single-step operation. When any enabled entry matches on a retire, the unit raises a one-cycle break request and reports which entry fired. The core then stops with a debugger-triggered status, separate from its halt and error states.

Entries are loaded, enabled, disabled and deleted one at a time through a small command interface. For memory entries, the unit drives the watched address of every entry on a flat address bus. The surrounding system returns the word stored at each of those addresses on a matching flat read-back bus, valid in the retire cycle.

Top module: `break_watch`

## Requirements
- R1: After reset, `breakReq` is 0, `breakIdx` is 0 and every entry is disabled with kind 0, target 0 and constant 0, so a retire raises no break.
- R2: `breakReq` is 1 in exactly the cycle after a clock edge where `retireValid` was 1 and at least one enabled entry matched. Otherwise it is 0.
- R3: When several entries match, `breakIdx` reports the lowest-numbered one. `breakIdx` changes only together with a break and holds its value until the next break.
- R4: Kind code 2 compares `retirePc` against the entry constant. Operator codes are 0 equal, 1 not equal, 2 less than, 3 less-or-equal, 4 greater than and 5 greater-or-equal. All comparisons are unsigned, and the operand stands on the left of the operator.
- R5: Kind code 3 compares register `target[2:0]` (R0 to R7, register n at `regFile[32n+31:32n]`) against the constant.
- R6: Kind code 4 compares the data-memory word `memWord[32i+31:32i]` against the constant for entry i. `watchAddr[32i+31:32i]` always equals entry i's stored target.
- R7: Kind code 1 (single step) matches on every retire, whatever its operator or constant.
- R8: Kind codes 0 and 5 to 7, and operator codes 6 and 7 on kinds 2 to 4, never match.
- R9: Command 0 writes enable, kind, operator, target and constant. Command 1 sets only the enable. Command 2 clears only the enable and keeps the rest. Command 3 deletes the entry, returning it to its reset state.
- R10: A command takes effect at the clock edge that accepts it. A retire in that same cycle is judged against the table as it stood before the command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgValid | input | 1 | Command strobe |
| cfgCmd | input | 2 | 0 write, 1 enable, 2 disable, 3 delete |
| cfgIdx | input | 3 | Entry selected by the command |
| cfgEnable | input | 1 | Enable value for a write |
| cfgKind | input | 3 | Entry kind for a write |
| cfgOp | input | 3 | Relational operator for a write |
| cfgTarget | input | 32 | Register number or memory address for a write |
| cfgConst | input | 32 | Comparison constant for a write |
| retireValid | input | 1 | One instruction retires this cycle |
| retirePc | input | 32 | Program counter of the retiring instruction |
| regFile | input | 256 | Register file contents, R0 in the low word |
| memWord | input | 256 | Data-memory words read at each entry's watched address |
| watchAddr | output | 256 | Watched address of each entry, entry 0 in the low word |
| breakReq | output | 1 | One-cycle break request |
| breakIdx | output | 3 | Index of the entry that caused the latest break |

## Verification
The assertions assume that `memWord` carries, in every retire cycle, the contents at the addresses currently shown on `watchAddr`. They also assume that commands never target an out-of-range index, which the default eight-entry table makes impossible. The bench meets the first assumption by deriving each read-back word from its own model of the entry targets, using a fixed address-to-data function. Random stimulus keeps PC values, register values, targets and constants within a small range so that equality and ordering matches occur often. Directed sequences cover the unsigned wrap case, same-cycle command and retire, and deletion followed by re-enable.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam logic [2:0] KIND_NONE = 3'd0;
  localparam logic [2:0] KIND_STEP = 3'd1;
  localparam logic [2:0] KIND_PC   = 3'd2;
  localparam logic [2:0] KIND_REG  = 3'd3;
  localparam logic [2:0] KIND_MEM  = 3'd4;

  localparam logic [1:0] CMD_WRITE = 2'd0;
  localparam logic [1:0] CMD_EN    = 2'd1;
  localparam logic [1:0] CMD_DIS   = 2'd2;
  localparam logic [1:0] CMD_DEL   = 2'd3;

  typedef struct packed {
    logic load;
    logic enSet;
    logic enClr;
    logic drop;
  } cfgStb_t;

  function automatic logic relMatch(input logic [2:0] op, input logic [31:0] a,
                                    input logic [31:0] b);
    case (op)
      3'd0:    return a == b;
      3'd1:    return a != b;
      3'd2:    return a < b;
      3'd3:    return a <= b;
      3'd4:    return a > b;
      3'd5:    return a >= b;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/brk_table.sv
module brk_table
  import brk_pkg::*;
#(
  parameter int N    = 8,
  parameter int DW   = 32,
  parameter int NREG = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  cfgStb_t [N-1:0]   stb,
  input  logic              cfgEnable,
  input  logic [2:0]        cfgKind,
  input  logic [2:0]        cfgOp,
  input  logic [DW-1:0]     cfgTarget,
  input  logic [DW-1:0]     cfgConst,
  input  logic [DW-1:0]     retirePc,
  input  logic [NREG*DW-1:0] regFile,
  input  logic [N*DW-1:0]   memWord,
  output logic [N-1:0]      hitVec,
  output logic [N*DW-1:0]   watchAddr
);
  localparam int RSW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [DW-1:0] regArr [NREG];
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    assign regArr[r] = regFile[r*DW +: DW];
  end

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic          enReg;
    logic [2:0]    kindReg;
    logic [2:0]    opReg;
    logic [DW-1:0] tgtReg;
    logic [DW-1:0] constReg;
    logic [DW-1:0] opA;
    logic          isCmp;

    always_ff @(posedge clk) begin
      if (rst || stb[g].drop) begin
        enReg    <= 1'b0;
        kindReg  <= KIND_NONE;
        opReg    <= 3'd0;
        tgtReg   <= '0;
        constReg <= '0;
      end else if (stb[g].load) begin
        enReg    <= cfgEnable;
        kindReg  <= cfgKind;
        opReg    <= cfgOp;
        tgtReg   <= cfgTarget;
        constReg <= cfgConst;
      end else if (stb[g].enSet) begin
        enReg <= 1'b1;
      end else if (stb[g].enClr) begin
        enReg <= 1'b0;
      end
    end

    always_comb begin
      isCmp = 1'b1;
      case (kindReg)
        KIND_PC:  opA = retirePc;
        KIND_REG: opA = regArr[tgtReg[RSW-1:0]];
        KIND_MEM: opA = memWord[g*DW +: DW];
        default: begin
          opA   = retirePc;
          isCmp = 1'b0;
        end
      endcase
    end

    assign hitVec[g] = enReg && ((kindReg == KIND_STEP) ||
                                 (isCmp && relMatch(opReg, opA, constReg)));
    assign watchAddr[g*DW +: DW] = tgtReg;
  end
endmodule

// File: rtl/brk_ctrl.sv
module brk_ctrl
  import brk_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgValid,
  input  logic [1:0]       cfgCmd,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic             retireValid,
  input  logic [N-1:0]     hitVec,
  output cfgStb_t [N-1:0]  stb,
  output logic             breakReq,
  output logic [IDX_W-1:0] breakIdx
);
  logic [IDX_W-1:0] winIdx;
  logic             anyHit;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      stb[i] = '0;
      if (cfgValid && cfgIdx == IDX_W'(i)) begin
        case (cfgCmd)
          CMD_WRITE: stb[i].load  = 1'b1;
          CMD_EN:    stb[i].enSet = 1'b1;
          CMD_DIS:   stb[i].enClr = 1'b1;
          default:   stb[i].drop  = 1'b1;
        endcase
      end
    end
  end

  always_comb begin
    winIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hitVec[i]) winIdx = IDX_W'(i);
    end
  end

  assign anyHit = |hitVec;

  always_ff @(posedge clk) begin
    if (rst) begin
      breakReq <= 1'b0;
      breakIdx <= '0;
    end else begin
      breakReq <= retireValid && anyHit;
      if (retireValid && anyHit) breakIdx <= winIdx;
    end
  end
endmodule

// File: rtl/break_watch.sv
module break_watch
  import brk_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int DATA_W      = 32,
  parameter int NUM_REGS    = 8,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfgValid,
  input  logic [1:0]                 cfgCmd,
  input  logic [IDX_W-1:0]           cfgIdx,
  input  logic                       cfgEnable,
  input  logic [2:0]                 cfgKind,
  input  logic [2:0]                 cfgOp,
  input  logic [DATA_W-1:0]          cfgTarget,
  input  logic [DATA_W-1:0]          cfgConst,
  input  logic                       retireValid,
  input  logic [DATA_W-1:0]          retirePc,
  input  logic [NUM_REGS*DATA_W-1:0] regFile,
  input  logic [NUM_ENTRIES*DATA_W-1:0] memWord,
  output logic [NUM_ENTRIES*DATA_W-1:0] watchAddr,
  output logic                       breakReq,
  output logic [IDX_W-1:0]           breakIdx
);
  cfgStb_t [NUM_ENTRIES-1:0] stb;
  logic    [NUM_ENTRIES-1:0] hitVec;

  brk_ctrl #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .cfgValid(cfgValid), .cfgCmd(cfgCmd), .cfgIdx(cfgIdx),
    .retireValid(retireValid), .hitVec(hitVec), .stb(stb),
    .breakReq(breakReq), .breakIdx(breakIdx)
  );

  brk_table #(.N(NUM_ENTRIES), .DW(DATA_W), .NREG(NUM_REGS)) u_table (
    .clk(clk), .rst(rst), .stb(stb), .cfgEnable(cfgEnable), .cfgKind(cfgKind),
    .cfgOp(cfgOp), .cfgTarget(cfgTarget), .cfgConst(cfgConst),
    .retirePc(retirePc), .regFile(regFile), .memWord(memWord),
    .hitVec(hitVec), .watchAddr(watchAddr)
  );
endmodule

// File: rtl/break_watch_chk.sv
module break_watch_chk #(
  parameter int N     = 8,
  parameter int DW    = 32,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cfgValid,
  input logic             retireValid,
  input logic [N-1:0]     hitVec,
  input logic             breakReq,
  input logic [IDX_W-1:0] breakIdx,
  input logic [N*DW-1:0]  watchAddr
);
  p_req_after_retire_r2: assert property (@(posedge clk) disable iff (rst)
    breakReq |-> $past(retireValid));

  p_hit_breaks_r2: assert property (@(posedge clk) disable iff (rst)
    (retireValid && (|hitVec)) |=> breakReq);

  p_idx_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !breakReq |-> $stable(breakIdx));

  p_lowest_wins_r3: assert property (@(posedge clk) disable iff (rst)
    (retireValid && hitVec[0]) |=> (breakReq && breakIdx == '0));

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(cfgValid) |-> $stable(watchAddr));
endmodule

bind break_watch break_watch_chk #(.N(NUM_ENTRIES), .DW(DATA_W), .IDX_W(IDX_W)) chk (
  .clk(clk), .rst(rst), .cfgValid(cfgValid), .retireValid(retireValid),
  .hitVec(hitVec), .breakReq(breakReq), .breakIdx(breakIdx), .watchAddr(watchAddr)
);

// File: tb/break_watch_test.sv
module break_watch_test;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgValid = 1'b0;
  logic [1:0] cfgCmd = '0;
  logic [2:0] cfgIdx = '0;
  logic cfgEnable = 1'b0;
  logic [2:0] cfgKind = '0, cfgOp = '0;
  logic [31:0] cfgTarget = '0, cfgConst = '0;
  logic retireValid = 1'b0;
  logic [31:0] retirePc = '0;
  logic [255:0] regFile = '0;
  logic [255:0] memWord = '0;
  logic [255:0] watchAddr;
  logic breakReq;
  logic [2:0] breakIdx;

  break_watch uut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit          mEn [N];
  logic [2:0]  mKind [N], mOp [N];
  logic [31:0] mTgt [N], mCst [N];
  logic [31:0] rf [8];
  logic [2:0]  lastIdx = '0;

  function automatic logic [31:0] memAt(logic [31:0] a);
    return (a * 32'd3 + 32'd1) & 32'hF;
  endfunction

  function automatic bit opTrue(logic [2:0] op, logic [31:0] x, logic [31:0] c);
    bit r = 1'b0;
    if (op == 3'd0) r = (x == c);
    else if (op == 3'd1) r = !(x == c);
    else if (op == 3'd2) r = !(x >= c);
    else if (op == 3'd3) r = !(x > c);
    else if (op == 3'd4) r = !(x <= c);
    else if (op == 3'd5) r = !(x < c);
    return r;
  endfunction

  function automatic int expWinner();
    for (int i = 0; i < N; i++) begin
      bit m = 1'b0;
      if (mEn[i]) begin
        if (mKind[i] == 3'd1) m = 1'b1;
        else if (mKind[i] == 3'd2) m = opTrue(mOp[i], retirePc, mCst[i]);
        else if (mKind[i] == 3'd3) m = opTrue(mOp[i], rf[mTgt[i][2:0]], mCst[i]);
        else if (mKind[i] == 3'd4) m = opTrue(mOp[i], memAt(mTgt[i]), mCst[i]);
      end
      if (m) return i;
    end
    return -1;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < N; i++) begin
      mEn[i] = 1'b0; mKind[i] = '0; mOp[i] = '0; mTgt[i] = '0; mCst[i] = '0;
    end
  endtask

  // called just after a falling edge with inputs set; checks after next falling edge
  task automatic tick(string tag);
    int w;
    for (int i = 0; i < 8; i++) regFile[i*32 +: 32] = rf[i];
    for (int i = 0; i < N; i++) memWord[i*32 +: 32] = memAt(mTgt[i]);
    w = retireValid ? expWinner() : -1;
    if (cfgValid) begin
      case (cfgCmd)
        2'd0: begin
          mEn[cfgIdx] = cfgEnable; mKind[cfgIdx] = cfgKind; mOp[cfgIdx] = cfgOp;
          mTgt[cfgIdx] = cfgTarget; mCst[cfgIdx] = cfgConst;
        end
        2'd1: mEn[cfgIdx] = 1'b1;
        2'd2: mEn[cfgIdx] = 1'b0;
        default: begin
          mEn[cfgIdx] = 1'b0; mKind[cfgIdx] = '0; mOp[cfgIdx] = '0;
          mTgt[cfgIdx] = '0; mCst[cfgIdx] = '0;
        end
      endcase
    end
    @(negedge clk);
    chk(breakReq == (w >= 0), tag, 32'(breakReq), 32'(w >= 0));
    if (w >= 0) lastIdx = 3'(w);
    chk(breakIdx == lastIdx, tag, 32'(breakIdx), 32'(lastIdx));
    for (int i = 0; i < N; i++)
      if (watchAddr[i*32 +: 32] !== mTgt[i])
        chk(1'b0, "R6 watchAddr", watchAddr[i*32 +: 32], mTgt[i]);
    cfgValid = 1'b0;
    retireValid = 1'b0;
  endtask

  task automatic cfg(logic [1:0] c, int idx, bit en, logic [2:0] k, logic [2:0] o,
                     logic [31:0] t, logic [31:0] v, string tag);
    cfgValid = 1'b1; cfgCmd = c; cfgIdx = 3'(idx); cfgEnable = en;
    cfgKind = k; cfgOp = o; cfgTarget = t; cfgConst = v;
    tick(tag);
  endtask

  task automatic retire(logic [31:0] pc, string tag);
    retireValid = 1'b1; retirePc = pc;
    tick(tag);
  endtask

  task automatic clearAll();
    for (int i = 0; i < N; i++) cfg(2'd3, i, 1'b0, 3'd0, 3'd0, 0, 0, "R9 delete");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'd20240611;
    void'($urandom(seed));
    modelReset();
    for (int i = 0; i < 8; i++) rf[i] = 32'(i * 2);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(breakReq == 1'b0, "R1 reset req", 32'(breakReq), 0);
    chk(breakIdx == 3'd0, "R1 reset idx", 32'(breakIdx), 0);
    retire(32'd0, "R1 idle table");

    // R4 PC compare
    cfg(2'd0, 2, 1'b1, 3'd2, 3'd0, 0, 32'd3, "R4 load");
    retire(32'd3, "R4 pc eq hit");
    retire(32'd4, "R4 pc eq miss");
    cfg(2'd0, 2, 1'b1, 3'd2, 3'd5, 0, 32'h80, "R4 load ge");
    retire(32'h80, "R4 pc ge hit");
    retire(32'h7F, "R4 pc ge miss");
    cfg(2'd0, 2, 1'b1, 3'd2, 3'd2, 0, 32'd1, "R4 load lt");
    retire(32'hFFFF_FFFF, "R4 unsigned lt miss");
    retire(32'd0, "R4 lt hit");
    clearAll();

    // R5 register compare
    rf[5] = 32'd77;
    cfg(2'd0, 4, 1'b1, 3'd3, 3'd0, 32'd5, 32'd77, "R5 load");
    retire(32'd9, "R5 reg hit");
    rf[5] = 32'd78;
    retire(32'd9, "R5 reg miss");
    clearAll();

    // R6 memory compare
    cfg(2'd0, 6, 1'b1, 3'd4, 3'd0, 32'd4, memAt(32'd4), "R6 load");
    retire(32'd1, "R6 mem hit");
    cfg(2'd0, 6, 1'b1, 3'd4, 3'd1, 32'd4, memAt(32'd4), "R6 load ne");
    retire(32'd1, "R6 mem ne miss");
    clearAll();

    // R7 single step, R3 lowest wins and hold
    cfg(2'd0, 7, 1'b1, 3'd1, 3'd7, 0, 32'd123, "R7 load");
    retire(32'd10, "R7 step");
    retire(32'd11, "R7 step again");
    cfg(2'd0, 3, 1'b1, 3'd2, 3'd0, 0, 32'd12, "R3 load");
    retire(32'd12, "R3 lowest wins");
    retire(32'd13, "R3 other entry");
    @(negedge clk);
    chk(breakReq == 1'b0, "R2 no retire", 32'(breakReq), 0);
    chk(breakIdx == 3'd7, "R3 idx hold", 32'(breakIdx), 7);
    clearAll();

    // R8 bad codes
    cfg(2'd0, 1, 1'b1, 3'd2, 3'd6, 0, 32'd5, "R8 load op6");
    retire(32'd5, "R8 op6 never");
    cfg(2'd0, 1, 1'b1, 3'd5, 3'd0, 0, 32'd5, "R8 load kind5");
    retire(32'd5, "R8 kind5 never");
    cfg(2'd0, 1, 1'b1, 3'd0, 3'd0, 0, 32'd5, "R8 load kind0");
    retire(32'd5, "R8 kind0 never");
    clearAll();

    // R9 enable/disable/delete
    cfg(2'd0, 0, 1'b0, 3'd2, 3'd0, 32'd9, 32'd20, "R9 load disabled");
    retire(32'd20, "R9 disabled miss");
    cfg(2'd1, 0, 1'b0, 3'd0, 3'd0, 0, 0, "R9 enable");
    retire(32'd20, "R9 enabled hit");
    cfg(2'd2, 0, 1'b1, 3'd1, 3'd0, 0, 0, "R9 disable");
    retire(32'd20, "R9 disabled again");
    cfg(2'd3, 0, 1'b0, 3'd0, 3'd0, 0, 0, "R9 delete");
    cfg(2'd1, 0, 1'b0, 3'd0, 3'd0, 0, 0, "R9 enable after delete");
    retire(32'd0, "R9 deleted entry quiet");

    // R10 same-cycle command and retire
    retireValid = 1'b1; retirePc = 32'd30;
    cfg(2'd0, 5, 1'b1, 3'd2, 3'd0, 0, 32'd30, "R10 new entry not yet");
    retire(32'd30, "R10 entry live");
    retireValid = 1'b1; retirePc = 32'd30;
    cfg(2'd2, 5, 1'b0, 3'd0, 3'd0, 0, 0, "R10 disable same cycle still hits");
    retire(32'd30, "R10 now disabled");
    clearAll();

    // random mix, R2 R3 R4 R5 R6 R7
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < 8; i++) rf[i] = $urandom_range(0, 15);
      retireValid = ($urandom_range(0, 3) != 0);
      retirePc = $urandom_range(0, 15);
      if ($urandom_range(0, 2) == 0) begin
        cfgValid = 1'b1;
        cfgCmd = 2'($urandom_range(0, 9) < 6 ? 0 : $urandom_range(1, 3));
        cfgIdx = 3'($urandom_range(0, 7));
        cfgEnable = ($urandom_range(0, 3) != 0);
        cfgKind = 3'($urandom_range(0, 9) < 8 ? $urandom_range(1, 4) : $urandom_range(0, 7));
        if (cfgKind == 3'd1 && $urandom_range(0, 3) != 0) cfgKind = 3'd2;
        cfgOp = 3'($urandom_range(0, 9) < 9 ? $urandom_range(0, 5) : $urandom_range(6, 7));
        cfgTarget = $urandom_range(0, 15);
        cfgConst = $urandom_range(0, 15);
      end
      tick("R2 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule